// File: doc/BRIEF.md
# Palette Entry Colour Converter

This block takes raw palette words, as fetched from memory for an indexed-colour display plane. It converts each word into one internal form: 8-bit red, green and blue plus a transparency flag. The converted entries go into a dual-port palette RAM. One of four packed source encodings is chosen by a 2-bit format select. A monochrome flag overrides the colour fields and copies the low byte into all three channels. The number of entries loaded follows the current pixel depth code. Codes for 2, 4 and 8 bits per pixel load 4, 16 and 256 entries. Any other code loads nothing.

A load begins with a one-cycle `start`. The block then accepts one raw word on each cycle that `in_valid` is high. It converts the word and writes it at the next free index, starting from zero. It signals `done` when the final entry is written. The RAM keeps a separate registered read port, so pixel lookups can go on while a reload is in progress. The block remembers the format select used by the most recent load. It raises `reconv_req` while the live select differs from that value, and also before any load has happened, so that control logic knows to reload the palette before the next frame.

Top module: `palette_loader`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are low and `reconv_req` is high.
- R2: A `start` while idle with depth code 1, 2 or 3 sets `busy` on the next cycle and loads exactly 4, 16 or 256 entries. `done` is high for one cycle, in the same cycle as the write of the last entry, and `busy` is low from that cycle on.
- R3: A `start` while idle with any other depth code (0 or 4 to 15) writes nothing, leaves `busy` low, and pulses `done` on the next cycle.
- R4: Format 0: R = {w[15:11],000}, G = {w[10:5],00}, B = {w[4:0],000}, and alpha is 0 whatever bit 24 holds.
- R5: Format 1: the same 5-6-5 layout as format 0, with alpha = w[24].
- R6: Format 2: R = {w[23:19],000}, G = {w[15:10],00}, B = {w[7:3],000}, and alpha = w[24].
- R7: Format 3: R = w[23:16], G = w[15:8], B = w[7:0], and alpha = w[24].
- R8: When `mono` is high, R, G and B all equal w[7:0] in every format. Alpha follows the format's rule.
- R9: A word present with `in_valid` at a clock edge during a load appears on the write port (`wr_en`, `wr_idx`, colour, alpha) right after that edge. Indices run 0, 1, 2 and so on. A cycle with `in_valid` low produces no write and does not advance the index.
- R10: The format select and the mono flag are captured at `start`. Changing them during a load has no effect on that load. A `start` during a load is ignored.
- R11: `reconv_req` is high when no load has started since reset, or when `fmt_sel` differs from the select captured by the latest `start`. Otherwise it is low.
- R12: The read port returns {alpha, R, G, B} of entry `rd_idx` one clock after `rd_idx` is sampled. It works while a load is running.
- R13: `in_valid` while idle causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a palette load (ignored while busy) |
| depth_code | input | 4 | Pixel depth code: 1=2bpp, 2=4bpp, 3=8bpp, others load nothing |
| fmt_sel | input | 2 | Palette source encoding select (0 to 3) |
| mono | input | 1 | Monochrome: copy low byte to all channels |
| in_valid | input | 1 | Raw word present |
| in_word | input | 25 | Bits 24:0 of the raw palette word (upper bits carry no meaning) |
| busy | output | 1 | Load in progress; words are accepted |
| done | output | 1 | One-cycle pulse at load completion |
| reconv_req | output | 1 | Palette must be reconverted |
| wr_en | output | 1 | Palette write strobe |
| wr_idx | output | 8 | Palette write index |
| wr_r | output | 8 | Converted red |
| wr_g | output | 8 | Converted green |
| wr_b | output | 8 | Converted blue |
| wr_alpha | output | 1 | Transparency flag |
| rd_idx | input | 8 | Lookup index |
| rd_rgb | output | 24 | Stored {R,G,B} of the looked-up entry |
| rd_alpha | output | 1 | Stored transparency flag of the looked-up entry |

## Verification
Each accepted word reaches the write port one edge after it is presented. `done` rises on that same edge for the last word, and `busy` rises one edge after `start`. The RAM takes the registered write one edge later, and a lookup returns data one edge after its index is sampled. So the entry a word creates can be read back no earlier than three edges after the word. `reconv_req` follows `fmt_sel` within the same cycle. The bench drives every input on the falling clock edge and samples on the next falling edge. Each expected value is therefore compared exactly one rising edge after its stimulus, and read-backs are done only after a load has finished.

// File: rtl/palette_fmt_pkg.sv
package palette_fmt_pkg;

  typedef struct packed {
    logic       a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pal_entry_t;

  localparam int unsigned ENTRY_W = $bits(pal_entry_t);

  // entries loaded for a given pixel depth code; 0 means none
  function automatic int unsigned entry_count(input logic [3:0] code);
    case (code)
      4'd1:    return 4;
      4'd2:    return 16;
      4'd3:    return 256;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/palette_seq.sv
module palette_seq
  import palette_fmt_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [3:0]       depth_code,
  input  logic [1:0]       fmt_sel,
  input  logic             mono,
  input  logic             in_valid,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic [IDX_W-1:0] idx,
  output logic [1:0]       fmt_l,
  output logic             mono_l,
  output logic             reconv_req
);

  logic [IDX_W:0] cnt_q;
  logic [IDX_W:0] n_eff;
  logic [IDX_W:0] idx_p1;
  logic [1:0]     last_fmt;
  logic           have_conv;
  int unsigned    n_req;

  always_comb begin
    n_req = entry_count(depth_code);
    n_eff = (n_req > ENTRIES) ? (IDX_W+1)'(ENTRIES) : (IDX_W+1)'(n_req);
  end

  assign idx_p1     = {1'b0, idx} + 1'b1;
  assign accept     = busy & in_valid;
  assign reconv_req = ~have_conv | (fmt_sel != last_fmt);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      idx       <= '0;
      cnt_q     <= '0;
      fmt_l     <= '0;
      mono_l    <= 1'b0;
      last_fmt  <= '0;
      have_conv <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        last_fmt  <= fmt_sel;
        have_conv <= 1'b1;
        fmt_l     <= fmt_sel;
        mono_l    <= mono;
        idx       <= '0;
        cnt_q     <= n_eff;
        if (n_eff == '0) done <= 1'b1;
        else             busy <= 1'b1;
      end else if (accept) begin
        idx <= idx_p1[IDX_W-1:0];
        if (idx_p1 == cnt_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/palette_decode.sv
module palette_decode
  import palette_fmt_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [IDX_W-1:0] idx,
  input  logic [24:0]      word,
  input  logic [1:0]       fmt,
  input  logic             mono,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output pal_entry_t       wr_ent
);

  pal_entry_t conv;

  always_comb begin
    case (fmt)
      2'd0: begin
        conv.a = 1'b0;
        conv.r = {word[15:11], 3'b000};
        conv.g = {word[10:5],  2'b00};
        conv.b = {word[4:0],   3'b000};
      end
      2'd1: begin
        conv.a = word[24];
        conv.r = {word[15:11], 3'b000};
        conv.g = {word[10:5],  2'b00};
        conv.b = {word[4:0],   3'b000};
      end
      2'd2: begin
        conv.a = word[24];
        conv.r = {word[23:19], 3'b000};
        conv.g = {word[15:10], 2'b00};
        conv.b = {word[7:3],   3'b000};
      end
      default: begin
        conv.a = word[24];
        conv.r = word[23:16];
        conv.g = word[15:8];
        conv.b = word[7:0];
      end
    endcase
    if (mono) begin
      conv.r = word[7:0];
      conv.g = word[7:0];
      conv.b = word[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en  <= 1'b0;
      wr_idx <= '0;
      wr_ent <= '0;
    end else begin
      wr_en <= accept;
      if (accept) begin
        wr_idx <= idx;
        wr_ent <= conv;
      end
    end
  end

endmodule

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned WIDTH   = 25,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/palette_loader.sv
module palette_loader
  import palette_fmt_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [3:0]       depth_code,
  input  logic [1:0]       fmt_sel,
  input  logic             mono,
  input  logic             in_valid,
  input  logic [24:0]      in_word,
  output logic             busy,
  output logic             done,
  output logic             reconv_req,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_r,
  output logic [7:0]       wr_g,
  output logic [7:0]       wr_b,
  output logic             wr_alpha,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [23:0]      rd_rgb,
  output logic             rd_alpha
);

  logic             accept;
  logic [IDX_W-1:0] idx;
  logic [1:0]       fmt_l;
  logic             mono_l;
  pal_entry_t       wr_ent;
  logic [ENTRY_W-1:0] rd_q;

  palette_seq #(.ENTRIES(ENTRIES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .depth_code(depth_code),
    .fmt_sel(fmt_sel), .mono(mono), .in_valid(in_valid),
    .busy(busy), .done(done), .accept(accept), .idx(idx),
    .fmt_l(fmt_l), .mono_l(mono_l), .reconv_req(reconv_req)
  );

  palette_decode #(.ENTRIES(ENTRIES)) u_dec (
    .clk(clk), .rst(rst), .accept(accept), .idx(idx), .word(in_word),
    .fmt(fmt_l), .mono(mono_l), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent)
  );

  palette_ram #(.ENTRIES(ENTRIES), .WIDTH(ENTRY_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_ent),
    .raddr(rd_idx), .rdata(rd_q)
  );

  assign wr_r     = wr_ent.r;
  assign wr_g     = wr_ent.g;
  assign wr_b     = wr_ent.b;
  assign wr_alpha = wr_ent.a;
  assign rd_rgb   = rd_q[23:0];
  assign rd_alpha = rd_q[24];

endmodule

// File: rtl/palette_loader_chk.sv
module palette_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [3:0] depth_code,
  input logic [1:0] fmt_sel,
  input logic       in_valid,
  input logic       busy,
  input logic       done,
  input logic       reconv_req,
  input logic       wr_en,
  input logic       wr_alpha
);

  logic [1:0] fmt_cap;
  logic       go, depth_ok;

  assign go       = start && !busy;
  assign depth_ok = (depth_code == 4'd1) || (depth_code == 4'd2) || (depth_code == 4'd3);

  always_ff @(posedge clk) begin
    if (rst) fmt_cap <= '0;
    else if (go) fmt_cap <= fmt_sel;
  end

  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    (go && depth_ok) |=> busy);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_unsupported_r3: assert property (@(posedge clk) disable iff (rst)
    (go && !depth_ok) |=> (done && !busy));

  p_fmt0_no_alpha_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fmt_cap == 2'd0) |-> !wr_alpha);

  p_accept_writes_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && in_valid) |=> wr_en);

  p_reconv_track_r11: assert property (@(posedge clk) disable iff (rst)
    go |=> (reconv_req == (fmt_sel != $past(fmt_sel))));

  p_idle_no_write_r13: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !wr_en);

endmodule

bind palette_loader palette_loader_chk u_chk (.*);

// File: tb/palette_loader_test.sv
`timescale 1ns/1ps
module palette_loader_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  depth_code = '0;
  logic [1:0]  fmt_sel = '0;
  logic        mono = 1'b0;
  logic        in_valid = 1'b0;
  logic [24:0] in_word = '0;
  logic        busy, done, reconv_req, wr_en, wr_alpha, rd_alpha;
  logic [7:0]  wr_idx, wr_r, wr_g, wr_b;
  logic [7:0]  rd_idx = '0;
  logic [23:0] rd_rgb;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [24:0] exp_mem [256];

  palette_loader uut (
    .clk(clk), .rst(rst), .start(start), .depth_code(depth_code),
    .fmt_sel(fmt_sel), .mono(mono), .in_valid(in_valid), .in_word(in_word),
    .busy(busy), .done(done), .reconv_req(reconv_req), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_r(wr_r), .wr_g(wr_g), .wr_b(wr_b),
    .wr_alpha(wr_alpha), .rd_idx(rd_idx), .rd_rgb(rd_rgb), .rd_alpha(rd_alpha)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {alpha,R,G,B} per the format rules
  function automatic logic [24:0] model(input logic [24:0] w, input logic [1:0] f,
                                       input logic m);
    logic a;
    logic [7:0] r, g, b;
    a = (f == 2'd0) ? 1'b0 : w[24];
    if (f == 2'd3)      begin r = w[23:16]; g = w[15:8]; b = w[7:0]; end
    else if (f == 2'd2) begin r = {w[23:19],3'd0}; g = {w[15:10],2'd0}; b = {w[7:3],3'd0}; end
    else                begin r = {w[15:11],3'd0}; g = {w[10:5],2'd0}; b = {w[4:0],3'd0}; end
    if (m) begin r = w[7:0]; g = w[7:0]; b = w[7:0]; end
    return {a, r, g, b};
  endfunction

  task automatic load(input logic [3:0] dc, input logic [1:0] f, input logic m,
                      input int stall_pct, input bit wiggle, input bit poke,
                      input string req);
    int n;
    n = (dc == 4'd1) ? 4 : (dc == 4'd2) ? 16 : 256;
    start = 1'b1; depth_code = dc; fmt_sel = f; mono = m;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
    for (int i = 0; i < n; ) begin
      bit v;
      logic [24:0] w;
      logic [24:0] e;
      v = ($urandom % 100) >= stall_pct;
      w = 25'($urandom);
      in_valid = v; in_word = w;
      if (wiggle) begin fmt_sel = 2'($urandom); mono = 1'($urandom); end
      if (poke && i == 1) begin start = 1'b1; depth_code = 4'd1; end
      @(negedge clk);
      start = 1'b0;
      if (v) begin
        e = model(w, f, m);
        chk(wr_en === 1'b1 && wr_idx === 8'(i) && {wr_alpha, wr_r, wr_g, wr_b} === e,
            $sformatf("%s R9 R10 entry %0d idx=%0d", req, i, wr_idx),
            {7'd0, wr_alpha, wr_r, wr_g, wr_b}, {7'd0, e});
        chk(done === (i == n - 1), "R2 done with last write", {31'd0, done},
            {31'd0, (i == n - 1)});
        exp_mem[i] = e;
        i++;
      end else begin
        chk(wr_en === 1'b0, "R9 stall no write", {31'd0, wr_en}, 32'd0);
      end
    end
    in_valid = 1'b0; fmt_sel = f; mono = m;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && wr_en === 1'b0, "R2 idle after load",
        {29'd0, done, busy, wr_en}, 32'd0);
    chk(reconv_req === 1'b0, "R11 no reconv after load", {31'd0, reconv_req}, 32'd0);
  endtask

  task automatic readback(input int idx);
    rd_idx = 8'(idx);
    @(negedge clk);
    chk({rd_alpha, rd_rgb} === exp_mem[idx], $sformatf("R12 read entry %0d", idx),
        {7'd0, rd_alpha, rd_rgb}, {7'd0, exp_mem[idx]});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy === 0 && done === 0 && wr_en === 0 && reconv_req === 1, "R1 reset state",
        {28'd0, busy, done, wr_en, reconv_req}, 32'd1);

    // R3 unsupported depth codes
    foreach (depth_code_list[k]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [3:0] dc;
      dc = (k == 0) ? 4'd0 : (k == 1) ? 4'd4 : (k == 2) ? 4'd9 : 4'd15;
      start = 1'b1; depth_code = dc; fmt_sel = 2'd1;
      @(negedge clk);
      start = 1'b0;
      chk(done === 1 && busy === 0 && wr_en === 0, $sformatf("R3 depth %0d", dc),
          {29'd0, done, busy, wr_en}, 32'd4);
      @(negedge clk);
      chk(done === 0 && wr_en === 0, "R3 no later write", {30'd0, done, wr_en}, 32'd0);
    end
    chk(reconv_req === 0, "R11 format captured", {31'd0, reconv_req}, 32'd0);

    // R13 in_valid while idle
    in_valid = 1'b1; in_word = 25'h1ABCDEF;
    @(negedge clk);
    chk(wr_en === 0 && busy === 0, "R13 idle word ignored", {30'd0, wr_en, busy}, 32'd0);
    in_valid = 1'b0;

    // R7 full 256-entry load, format 3, with stalls
    load(4'd3, 2'd3, 1'b0, 30, 1'b0, 1'b0, "R7 R2");
    for (int k = 0; k < 8; k++) readback(int'($urandom % 256));
    readback(255);

    // R4 format 0 short load, inputs wiggled, start poked; R12 read during load
    rd_idx = 8'd200;
    load(4'd1, 2'd0, 1'b0, 20, 1'b1, 1'b1, "R4 R10");
    chk({rd_alpha, rd_rgb} === exp_mem[200], "R12 read during load",
        {7'd0, rd_alpha, rd_rgb}, {7'd0, exp_mem[200]});
    readback(3);

    load(4'd2, 2'd1, 1'b0, 10, 1'b0, 1'b0, "R5");
    load(4'd2, 2'd2, 1'b0, 10, 1'b0, 1'b0, "R6");
    readback(7);
    load(4'd1, 2'd0, 1'b1, 0, 1'b0, 1'b0, "R8 fmt0");
    load(4'd2, 2'd3, 1'b1, 25, 1'b1, 1'b0, "R8 fmt3");

    // R11 format change detection
    fmt_sel = 2'd1;
    #0.5;
    chk(reconv_req === 1, "R11 change flagged", {31'd0, reconv_req}, 32'd1);
    @(negedge clk);
    fmt_sel = 2'd3;
    #0.5;
    chk(reconv_req === 0, "R11 change reverted", {31'd0, reconv_req}, 32'd0);
    @(negedge clk);

    // random loads
    for (int k = 0; k < 6; k++) begin
      load(4'(1 + $urandom % 3), 2'($urandom), 1'($urandom), 20, 1'b1, 1'b0,
           "R2 R9 random");
      readback(0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int depth_code_list [1];

endmodule